// File: doc/BRIEF.md
# Serial Receiver with Line Status

This block is the receive half of an asynchronous serial port. It watches an idle-high serial line, finds the falling edge of a start bit, and times each following bit from a 16x oversampling tick so that every bit is sampled near its middle. It assembles a character of 5, 6, 7 or 8 data bits, least significant bit first. It can check a parity bit, and it always checks one stop bit. Each finished character goes into a receive FIFO together with three error bits: parity, framing and break.

A host pops characters from the FIFO head. It also reads a six-bit line status word. The overrun, parity, framing and break bits in that word are sticky and clear when the host pulses the status-read strobe. The data-ready bit and the FIFO-error bit follow the FIFO contents. The baud-rate tick and the register decode are made outside this block.

Top module: `serial_rx_linestat`

## Requirements
- R1: A character begins only when the synchronised line, sampled on a tick, is 0 and was 1 on the previous tick. The start bit is sampled again on the 8th tick after that. If the line is 1 there, the event is a glitch and no character is produced.
- R2: Data bits arrive least significant bit first. Each later bit is sampled 16 ticks after the previous sample. The word-length code `wlen` is 00, 01, 10 or 11 for 5, 6, 7 or 8 bits. Data bits above the word length read as 0 in `rx_data`.
- R3: When `par_en`=1 one parity bit follows the data. `par_sel` is 00 for odd, 01 for even, 10 for a bit forced to 1 and 11 for a bit forced to 0. A mismatch sets the entry's parity bit (`rx_err[0]`) and the parity flag (`line_status[2]`). When `par_en`=0 no parity bit is expected.
- R4: A stop bit sampled as 0 sets the entry's framing bit (`rx_err[1]`) and the framing flag (`line_status[3]`), unless the character is a break.
- R5: A character whose data, parity (if any) and stop bits are all 0 is a break. It stores data 0 with only the break bit (`rx_err[2]`) set and sets the break flag (`line_status[4]`). The receiver then ignores the line until the line has been 1 for one full character time, 16*(2+bits+par_en) ticks.
- R6: The FIFO holds up to FIFO_DEPTH entries in arrival order. A `rd_pop` pulse removes the head. `rx_data` and `rx_err` show the head, or 0 when the FIFO is empty.
- R7: When a character completes while the FIFO is full and no pop happens in that cycle, the character is discarded and the overrun flag (`line_status[1]`) is set. The character's parity and framing flags are still set.
- R8: A `stat_rd` pulse clears `line_status[4:1]` at the next clock edge. A flag that is being set in the same cycle stays set.
- R9: `line_status[0]` (data ready) is 1 exactly when the FIFO holds at least one entry.
- R10: `line_status[5]` is 1 while any entry still in the FIFO carries a parity, framing or break bit.
- R11: After reset `line_status` is 0, `rx_data` is 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| wlen | input | 2 | Word length code (00=5 .. 11=8 bits) |
| par_en | input | 1 | Parity bit present and checked |
| par_sel | input | 2 | Parity mode: odd, even, forced 1, forced 0 |
| rx_in | input | 1 | Serial line, idle high, asynchronous |
| rd_pop | input | 1 | Remove the FIFO head |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| rx_data | output | 8 | Data of the FIFO head |
| rx_err | output | 3 | Head error bits {break, framing, parity} |
| line_status | output | 6 | {fifo error, break, framing, parity, overrun, data ready} |

## Verification
The bench builds the block with FIFO_DEPTH=4 and keeps the 16x oversampling default. A fifth character arriving without a pop then reaches the overrun path within a few frames. The short FIFO also lets the bench hold an errored entry behind a clean one and watch the FIFO-error bit follow them out. Word lengths 5 and 8, all four parity modes, a stop-bit error, a start glitch and a long break followed by the idle wait all fit in a short run.

// File: rtl/serial_rx_pkg.sv
// Shared types for the serial receiver.
// Assumes the character width never exceeds 8 data bits.
package serial_rx_pkg;
    localparam int unsigned DATA_W = 8;

    // One FIFO entry: error bits above the data byte.
    typedef struct packed {
        logic              brk;
        logic              fe;
        logic              pe;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
    } rx_state_t;
endpackage

// File: rtl/rx_frame.sv
// Character assembler: start detection, centre sampling, parity, stop and break.
// Assumes rx_s is already synchronised and tick is a one-cycle strobe at OSR x baud.
module rx_frame
    import serial_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic [1:0] par_sel,
    output logic       push,
    output rx_entry_t  entry
);
    localparam int unsigned CW  = $clog2(OSR);
    localparam int unsigned HW  = $clog2(OSR * (DATA_W + 3) + 1);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_t         state;
    logic [CW-1:0]     cnt;
    logic [2:0]        idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              prev;
    logic [HW-1:0]     hold_cnt;
    logic [2:0]        last_idx;
    logic [HW-1:0]     char_ticks;
    logic              par_exp;
    logic              is_break;

    // Derive frame geometry and expected parity from the line settings.
    always_comb begin
        last_idx   = 3'd4 + {1'b0, wlen};
        char_ticks = HW'(OSR * (2 + 5 + int'(wlen) + int'(par_en)));
        case (par_sel)
            2'b00:   par_exp = ~^shreg;
            2'b01:   par_exp = ^shreg;
            2'b10:   par_exp = 1'b1;
            default: par_exp = 1'b0;
        endcase
        is_break = !rx_s && (shreg == '0) && (!par_en || !par_bit);
    end

    // Receive state machine driven by the oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            prev     <= 1'b1;
            hold_cnt <= '0;
            push     <= 1'b0;
            entry    <= '0;
        end else begin
            push <= 1'b0;
            if (tick) prev <= rx_s;
            case (state)
                ST_IDLE: if (tick && prev && !rx_s) begin
                    state <= ST_START;
                    cnt   <= '0;
                end
                ST_START: if (tick) begin
                    if (cnt == MID) begin
                        cnt <= '0;
                        if (rx_s) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_DATA;
                            idx   <= '0;
                            shreg <= '0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: if (tick) begin
                    if (cnt == LAST) begin
                        cnt        <= '0;
                        shreg[idx] <= rx_s;
                        if (idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
                        else                 idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: if (tick) begin
                    if (cnt == LAST) begin
                        cnt     <= '0;
                        par_bit <= rx_s;
                        state   <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: if (tick) begin
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        push <= 1'b1;
                        if (is_break) begin
                            entry    <= '{brk: 1'b1, fe: 1'b0, pe: 1'b0, data: '0};
                            state    <= ST_HOLD;
                            hold_cnt <= '0;
                        end else begin
                            entry <= '{brk: 1'b0, fe: !rx_s,
                                       pe: par_en && (par_bit != par_exp), data: shreg};
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: if (tick) begin
                    if (!rx_s)                          hold_cnt <= '0;
                    else if (hold_cnt == char_ticks - 1) state   <= ST_IDLE;
                    else                                hold_cnt <= hold_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a start that is high again at the re-sample returns to idle
    a_r1_glitch_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick && cnt == MID && rx_s) |=> state == ST_IDLE);
    // R5: a break entry carries zero data and only the break bit
    a_r5_break_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (push && entry.brk) |-> (entry.data == '0 && !entry.fe && !entry.pe));
    // R5: while holding after a break, a low line keeps the receiver waiting
    a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !rx_s) |=> (state == ST_HOLD && !push));
    // R6: each character is pushed exactly once
    a_r6_push_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);
endmodule

// File: rtl/rx_fifo.sv
// Receive FIFO of character entries with a count of entries carrying errors.
// Assumes push and pop are single-cycle strobes; a push while full without pop is dropped.
module rx_fifo
    import serial_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t wdata,
    input  logic      pop,
    output logic      full,
    output logic      empty,
    output rx_entry_t head,
    output logic      err_any
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_C = (AW + 1)'(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   count, err_cnt;
    logic          do_push, do_pop, in_err, head_err;

    // Qualify strobes against occupancy.
    always_comb begin
        full     = (count == DEPTH_C);
        empty    = (count == '0);
        do_pop   = pop && !empty;
        do_push  = push && (!full || pop);
        head     = empty ? '0 : mem[rp];
        in_err   = wdata.brk | wdata.fe | wdata.pe;
        head_err = head.brk | head.fe | head.pe;
        err_any  = (err_cnt != '0);
    end

    // Store an accepted entry.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Advance pointers and occupancy counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            count   <= '0;
            err_cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count   <= count + (AW + 1)'(do_push) - (AW + 1)'(do_pop);
            err_cnt <= err_cnt + (AW + 1)'(do_push && in_err) - (AW + 1)'(do_pop && head_err);
        end
    end

    // R7: a push into a full FIFO without a pop leaves occupancy unchanged
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> count == $past(count));
    // R6: popping an empty FIFO with no push keeps it empty
    a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
    // R10: errored entries never outnumber stored entries
    a_r10_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= count);
endmodule

// File: rtl/rx_line_flags.sv
// Sticky line-status flags {break, framing, parity, overrun}, cleared by a status read.
// Assumes a set and a read in the same cycle resolve in favour of the set.
module rx_line_flags
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  rx_entry_t  entry,
    input  logic       overrun,
    input  logic       stat_rd,
    output logic [3:0] flags
);
    logic [3:0] set_vec;

    // Collect this cycle's flag events.
    always_comb set_vec = {push && entry.brk, push && entry.fe, push && entry.pe, overrun};

    // Set on an event, clear on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (set_vec[i])   flags[i] <= 1'b1;
                else if (stat_rd) flags[i] <= 1'b0;
            end
        end
    end

    // R8: a read with no new events clears every flag
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && set_vec == '0) |=> flags == '0);
    // R8: an event sets its flag even during a read
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/serial_rx_linestat.sv
// Top of the serial receiver: line synchroniser, frame assembler, FIFO and status flags.
// Assumes os_tick is a one-cycle strobe at 16x the bit rate (OSR parameter).
module serial_rx_linestat
    import serial_rx_pkg::*;
#(
    parameter int unsigned OSR        = 16,
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic [1:0] par_sel,
    input  logic       rx_in,
    input  logic       rd_pop,
    input  logic       stat_rd,
    output logic [7:0] rx_data,
    output logic [2:0] rx_err,
    output logic [5:0] line_status
);
    logic [1:0] sync;
    logic       push, full, empty, err_any, overrun;
    rx_entry_t  entry, head;
    logic [3:0] flags;

    // Bring the asynchronous line into the clock domain, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rx_in};
    end

    rx_frame #(.OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(sync[1]),
        .wlen(wlen), .par_en(par_en), .par_sel(par_sel),
        .push(push), .entry(entry)
    );

    rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(entry), .pop(rd_pop),
        .full(full), .empty(empty), .head(head), .err_any(err_any)
    );

    assign overrun = push && full && !rd_pop;

    rx_line_flags u_flags (
        .clk(clk), .rst_n(rst_n), .push(push), .entry(entry),
        .overrun(overrun), .stat_rd(stat_rd), .flags(flags)
    );

    assign rx_data     = head.data;
    assign rx_err      = {head.brk, head.fe, head.pe};
    assign line_status = {err_any, flags, !empty};

    // R9: data ready drops only through a pop
    a_r9_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (line_status[0] && !rd_pop) |=> line_status[0]);
endmodule

// File: tb/tb_serial_rx_linestat.sv
module tb_serial_rx_linestat;
    localparam int DEPTH = 4;
    localparam int OSR   = 16;

    logic       clk = 0, rst_n = 0, os_tick = 0;
    logic [1:0] wlen = 2'b11, par_sel = 2'b00;
    logic       par_en = 0, rx_in = 1, rd_pop = 0, stat_rd = 0;
    logic [7:0] rx_data;
    logic [2:0] rx_err;
    logic [5:0] line_status;

    int tests = 0, fails = 0;
    logic [1:0] tdiv = 0;

    // reference model
    int   q_data[$];
    int   q_err[$];
    logic m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0;

    serial_rx_linestat #(.OSR(OSR), .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wlen(wlen), .par_en(par_en),
        .par_sel(par_sel), .rx_in(rx_in), .rd_pop(rd_pop), .stat_rd(stat_rd),
        .rx_data(rx_data), .rx_err(rx_err), .line_status(line_status)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        tdiv    <= tdiv + 1;
        os_tick <= (tdiv == 2'd3);
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!os_tick);
        end
        @(negedge clk);
    endtask

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] ps);
        case (ps)
            2'b00:   return ~^d;
            2'b01:   return ^d;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int any_err();
        foreach (q_err[i]) if (q_err[i] != 0) return 1;
        return 0;
    endfunction

    task automatic model_push(input int d, input int e);
        if (e[0]) m_pe = 1;
        if (e[1]) m_fe = 1;
        if (e[2]) m_bi = 1;
        if (q_data.size() == DEPTH) m_oe = 1;
        else begin q_data.push_back(d); q_err.push_back(e); end
    endtask

    task automatic send_frame(input int nb, input logic [7:0] d, input logic pen,
                              input logic [1:0] ps, input logic pbit, input logic stopb);
        logic [7:0] md;
        int e;
        md = d & 8'((1 << nb) - 1);
        wlen = 2'(nb - 5); par_en = pen; par_sel = ps;
        rx_in = 0; wait_ticks(OSR);
        for (int i = 0; i < nb; i++) begin rx_in = md[i]; wait_ticks(OSR); end
        if (pen) begin rx_in = pbit; wait_ticks(OSR); end
        rx_in = stopb; wait_ticks(OSR);
        rx_in = 1; wait_ticks(OSR);
        if (md == 0 && (!pen || !pbit) && !stopb) e = 4;
        else e = ((!stopb) ? 2 : 0) | ((pen && pbit != exp_par(md, ps)) ? 1 : 0);
        model_push(e == 4 ? 0 : int'(md), e);
    endtask

    task automatic compare(input string req);
        int rdy;
        rdy = (q_data.size() != 0) ? 1 : 0;
        check({req, " data ready (R9)"}, int'(line_status[0]), rdy);
        check({req, " overrun"}, int'(line_status[1]), int'(m_oe));
        check({req, " parity flag"}, int'(line_status[2]), int'(m_pe));
        check({req, " framing flag"}, int'(line_status[3]), int'(m_fe));
        check({req, " break flag"}, int'(line_status[4]), int'(m_bi));
        check({req, " fifo error (R10)"}, int'(line_status[5]), any_err());
        check({req, " head data"}, int'(rx_data), rdy ? q_data[0] : 0);
        check({req, " head err"}, int'(rx_err), rdy ? q_err[0] : 0);
    endtask

    task automatic pop_one();
        rd_pop = 1; @(negedge clk); rd_pop = 0; @(negedge clk);
        if (q_data.size() != 0) begin void'(q_data.pop_front()); void'(q_err.pop_front()); end
    endtask

    task automatic read_status();
        stat_rd = 1; @(negedge clk); stat_rd = 0; @(negedge clk);
        m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        check("R11 status after reset", int'(line_status), 0);
        check("R11 data after reset", int'(rx_data), 0);
        wait_ticks(20);

        // R2: 8 bits, lsb first
        send_frame(8, 8'hA5, 0, 2'b00, 0, 1);
        compare("R2 8-bit A5");
        pop_one(); compare("R6 after pop");
        // R2: 5 bits, upper bits read as zero
        send_frame(5, 8'hF6, 0, 2'b00, 0, 1);
        compare("R2 5-bit");
        pop_one();
        send_frame(7, 8'h3C, 0, 2'b00, 0, 1);
        compare("R2 7-bit");
        pop_one();

        // R3: parity modes, correct and wrong
        send_frame(8, 8'h17, 1, 2'b00, exp_par(8'h17, 2'b00), 1);
        compare("R3 odd ok");
        pop_one();
        send_frame(8, 8'h17, 1, 2'b01, ~exp_par(8'h17, 2'b01), 1);
        compare("R3 even bad");
        pop_one(); read_status(); compare("R8 after read");
        send_frame(6, 8'h2A, 1, 2'b10, 1'b0, 1);
        compare("R3 mark bad");
        pop_one(); read_status();
        send_frame(6, 8'h2A, 1, 2'b11, 1'b0, 1);
        compare("R3 space ok");
        pop_one();

        // R4: framing error
        send_frame(8, 8'h55, 0, 2'b00, 0, 0);
        wait_ticks(OSR);
        compare("R4 framing");
        pop_one(); read_status(); compare("R8 clear framing");

        // R1: start glitch ignored
        rx_in = 0; wait_ticks(3); rx_in = 1; wait_ticks(3 * OSR);
        compare("R1 glitch");

        // R5: break, long low, then wait for a full character of idle
        wlen = 2'b11; par_en = 0;
        rx_in = 0; wait_ticks(10 * OSR + 3 * OSR);
        model_push(0, 4);
        compare("R5 break during low");
        rx_in = 1; wait_ticks(5 * OSR);
        rx_in = 0; wait_ticks(OSR); rx_in = 1; wait_ticks(2 * OSR);
        compare("R5 low pulse during hold ignored");
        wait_ticks(12 * OSR);
        send_frame(8, 8'h81, 0, 2'b00, 0, 1);
        compare("R5 frame after idle");
        pop_one(); pop_one(); read_status(); compare("R5 drained");

        // R10: errored entry behind a clean one
        send_frame(8, 8'h11, 0, 2'b00, 0, 1);
        send_frame(8, 8'h22, 1, 2'b01, ~exp_par(8'h22, 2'b01), 1);
        compare("R10 two entries");
        pop_one(); compare("R10 error entry at head");
        pop_one(); compare("R10 fifo empty");
        read_status();

        // R7: overrun on a full FIFO, order kept (R6)
        for (int k = 0; k < DEPTH + 1; k++)
            send_frame(8, 8'(8'h40 + k), 0, 2'b00, 0, (k == DEPTH) ? 1'b0 : 1'b1);
        wait_ticks(OSR);
        compare("R7 overrun");
        for (int k = 0; k < DEPTH; k++) begin pop_one(); compare("R6 drain order"); end
        read_status(); compare("R8 overrun cleared");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule